// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block gathers sixteen asynchronous interrupt request lines and records a rising edge on each of them in a pending-flag register. A second register holds one mask bit per line. A mask bit of one blocks its line, and a mask bit of zero lets it through. A fixed subset of the lines (sources 8, 9 and 10) is combined into one interrupt request toward the host processor. That request is high while any selected line is both pending and unmasked.

Software reaches both registers over a plain 16-bit register port that has a byte address, a write enable, write data and combinational read data. To find the active sources, software reads the flags and the mask. It acknowledges sources by writing the flag register with zeros in the bit positions it wants to clear. The block does no priority encoding and no vectoring.

Top module: `irqc_edge_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the flag register reads 0x0000 and `irq_o` is low.
- R2: A low-to-high change on `src_i[k]` sets flag bit k. The flag can be read after the third rising clock edge that follows the change: two edges for synchronisation and one for edge capture. A falling edge or a line that stays high sets nothing.
- R3: A write to byte address 0x2 (the flag register) clears each flag whose write-data bit is 0. Each flag whose write-data bit is 1 is left as it was.
- R4: When a captured edge and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R5: Byte address 0xA is the mask register, and it can be read and written. The written value is visible from the next cycle on. A mask bit of 1 blocks its source from `irq_o`.
- R6: `irq_o` is high exactly when one of flag bits 8, 9 or 10 is 1 and its mask bit is 0. It follows the registers in the same cycle they change.
- R7: A masked source still latches its flag. When its mask bit is later cleared, `irq_o` rises.
- R8: A pending flag on any source other than 8, 9 and 10 never raises `irq_o`, masked or not.
- R9: Reads from any address other than 0x2 and 0xA return 0. Writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 16 | Asynchronous interrupt request lines |
| addr_i | input | 4 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt request to the host |

## Verification
The hardest case to reach from the ports is the collision in which an edge is captured in the very cycle that software clears the same flag. The edge lands three clock edges after the line rises, so the stimulus raises a line and then issues a clear-all write exactly two cycles later. Random traffic then mixes line toggles with flag and mask writes and with writes to unused addresses. A bench model of the three-edge latency predicts every flag, mask and `irq_o` value after each cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_MASK = 2'd2
    } irqc_sel_e;

    function automatic irqc_sel_e decode_addr(input logic [3:0] addr,
                                              input logic [3:0] flag_addr,
                                              input logic [3:0] mask_addr);
        if (addr == flag_addr)      return SEL_FLAG;
        else if (addr == mask_addr) return SEL_MASK;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] line_i,
    output logic [N_SRC-1:0] rise_o
);
    typedef struct packed {
        logic [N_SRC-1:0] meta;
        logic [N_SRC-1:0] sync;
        logic [N_SRC-1:0] prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = line_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < N_SRC; k++) begin : g_rise
        assign rise_o[k] = st_q.sync[k] & ~st_q.prev[k];
    end

    // R2: a detected rise reflects a line that was low one cycle before
    p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((st_q.prev & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irqc_sel_e        sel_i,
    input  logic             wr_en_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic [N_SRC-1:0] rise_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] mask_o
);
    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] mask;
    } reg_state_t;

    reg_state_t rg_d, rg_q;
    logic [N_SRC-1:0] keep_d;

    always_comb begin
        rg_d   = rg_q;
        keep_d = '1;
        if (wr_en_i && sel_i == SEL_FLAG) keep_d = wr_data_i;
        rg_d.flag = (rg_q.flag & keep_d) | rise_i;
        if (wr_en_i && sel_i == SEL_MASK) rg_d.mask = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.flag <= '0;
            rg_q.mask <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign flag_o = rg_q.flag;
    assign mask_o = rg_q.mask;

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_FLAG) |=>
        ((flag_o & ~$past(wr_data_i) & ~$past(rise_i)) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((flag_o & $past(rise_i)) == $past(rise_i)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && sel_i == SEL_FLAG) |=>
        ((flag_o & $past(flag_o)) == $past(flag_o)));

    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_MASK) |=> (mask_o == $past(wr_data_i)));
endmodule

// File: rtl/irqc_edge_ctrl.sv
module irqc_edge_ctrl
    import irqc_pkg::*;
#(
    parameter int          N_SRC     = 16,
    parameter int          ADDR_W    = 4,
    parameter logic [3:0]  FLAG_ADDR = 4'h2,
    parameter logic [3:0]  MASK_ADDR = 4'hA,
    parameter logic [15:0] OUT_SEL   = 16'h0700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [N_SRC-1:0]  wr_data_i,
    output logic [N_SRC-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam logic [N_SRC-1:0] SEL_VEC = N_SRC'(OUT_SEL);

    irqc_sel_e        sel;
    logic [N_SRC-1:0] rise, flag_q, mask_q;

    assign sel = decode_addr(4'(addr_i), FLAG_ADDR, MASK_ADDR);

    irqc_sync_edge #(.N_SRC(N_SRC)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (src_i),
        .rise_o (rise)
    );

    irqc_regs #(.N_SRC(N_SRC)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rise_i    (rise),
        .flag_o    (flag_q),
        .mask_o    (mask_q)
    );

    always_comb begin
        unique case (sel)
            SEL_FLAG: rd_data_o = flag_q;
            SEL_MASK: rd_data_o = mask_q;
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_o = |(flag_q & ~mask_q & SEL_VEC);

    p_unused_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel == SEL_NONE) |=> (mask_q == $past(mask_q)));

    p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel == SEL_MASK && ((wr_data_i & SEL_VEC) == SEL_VEC))
        |=> !irq_o);

    p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & SEL_VEC) == '0) |-> !irq_o);
endmodule

// File: tb/test_irqc_edge_ctrl.sv
module test_irqc_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] src;
    logic [3:0]  addr;
    logic        wr_en;
    logic [15:0] wdata;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_flag, m_mask, h1, h2, h3;

    always #10 clk = ~clk;

    irqc_edge_ctrl i_irqc_edge_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wdata),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    function automatic logic exp_irq(input logic [15:0] f, input logic [15:0] m);
        return |(f & ~m & 16'h0700);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at posedge
    task automatic cyc(input logic [15:0] s, input logic w, input logic [3:0] a,
                       input logic [15:0] d);
        src = s; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        m_flag = (m_flag & ((w && a == 4'h2) ? d : 16'hFFFF)) | (h2 & ~h3);
        if (w && a == 4'hA) m_mask = d;
        h3 = h2; h2 = h1; h1 = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        addr = 4'h2; #1;
        check({req, " flags"}, rd_data, m_flag);
        addr = 4'hA; #1;
        check({req, " mask"}, rd_data, m_mask);
        check({req, " irq"}, {15'd0, irq}, {15'd0, exp_irq(m_flag, m_mask)});
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; src = '0; addr = '0; wr_en = 1'b0; wdata = '0;
        m_flag = '0; m_mask = 16'hFFFF; h1 = '0; h2 = '0; h3 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: latency and R6 output for source 9
        cyc(16'h0000, 1'b1, 4'hA, 16'h0000);
        cyc(16'h0200, 1'b0, 4'h0, 16'h0);
        cyc(16'h0200, 1'b0, 4'h0, 16'h0);
        addr = 4'h2; #1; check("R2 not yet after two edges", rd_data, 16'h0000);
        cyc(16'h0200, 1'b0, 4'h0, 16'h0);
        addr = 4'h2; #1; check("R2 set after third edge", rd_data, 16'h0200);
        check("R6 irq on", {15'd0, irq}, 16'd1);
        // falling edge sets nothing
        cyc(16'h0000, 1'b0, 4'h0, 16'h0);
        cyc(16'h0000, 1'b1, 4'h2, 16'hFFFF);
        repeat (3) cyc(16'h0000, 1'b0, 4'h0, 16'h0);
        check_all("R2 fall ignored");

        // R3: partial clear
        cyc(16'h0000, 1'b1, 4'h2, 16'hFDFF);
        addr = 4'h2; #1; check("R3 cleared bit 9", rd_data, 16'h0000);
        check("R6 irq off", {15'd0, irq}, 16'd0);

        // R8: non-selected source, unmasked
        cyc(16'h0001, 1'b0, 4'h0, 16'h0);
        repeat (3) cyc(16'h0001, 1'b0, 4'h0, 16'h0);
        addr = 4'h2; #1; check("R8 flag 0 set", rd_data, 16'h0001);
        check("R8 irq stays low", {15'd0, irq}, 16'd0);

        // R4: edge captured in the clearing cycle
        cyc(16'h0401, 1'b0, 4'h0, 16'h0);
        cyc(16'h0401, 1'b0, 4'h0, 16'h0);
        cyc(16'h0401, 1'b1, 4'h2, 16'h0000);
        addr = 4'h2; #1; check("R4 set wins", rd_data, 16'h0400);

        // R7: masked source latches, unmask raises irq
        cyc(16'h0401, 1'b1, 4'hA, 16'hFFFF);
        cyc(16'h0401, 1'b1, 4'h2, 16'h0000);
        cyc(16'h0501, 1'b0, 4'h0, 16'h0);
        repeat (3) cyc(16'h0501, 1'b0, 4'h0, 16'h0);
        addr = 4'h2; #1; check("R7 masked flag latched", rd_data, 16'h0100);
        check("R7 irq low while masked", {15'd0, irq}, 16'd0);
        cyc(16'h0501, 1'b1, 4'hA, 16'hFEFF);
        check("R7 irq after unmask", {15'd0, irq}, 16'd1);
        addr = 4'hA; #1; check("R5 mask readback", rd_data, 16'hFEFF);

        // R9: unused address
        cyc(16'h0501, 1'b1, 4'h4, 16'h0000);
        addr = 4'h4; #1; check("R9 unused reads zero", rd_data, 16'h0000);
        check_all("R9 unused write ignored");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] s;
            logic [3:0]  a;
            logic        w;
            s = (i % 4 == 0) ? 16'($urandom) : src;
            w = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: a = 4'h2;
                1: a = 4'hA;
                2: a = 4'h2;
                default: a = 4'($urandom);
            endcase
            cyc(s, w, a, 16'($urandom));
            check_all("R2 R3 R5 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule